// File: doc/BRIEF.md
# Interrupt Request Priority Core

This block keeps the pending-request and in-service state of an eight-line interrupt controller and drives the controller's interrupt output. Requests arrive on parallel input lines. Each one is either caught on its rising edge or sampled as a level, and it is latched only when its mask bit is clear. A separate configuration block supplies the mask, the vector base, the cascade map, the slave-present flag, the auto-EOI setting and the trigger mode.

The output is raised when the highest-numbered pending line is not blocked by an in-service line at the same position or above it. Line 7 always wins over line 0.

When the processor strobes acknowledge, the core moves the winning line from pending to in-service. With auto-EOI, the line is retired straight away instead. One clock later the core presents either a local vector, made from the base and the line number, or a flag telling the system that a cascaded slave supplies the vector. End-of-interrupt pulses retire in-service lines, either the highest one or a named one, and the output may then rise again for a request that was waiting.

Top module: `irq_prio_core`

## Requirements
- R1: A request on a line whose mask bit in `cfg_mask` is 1 is not latched, and `pend_o` keeps that bit 0. A request on an unmasked line sets its bit in `pend_o` on the next clock.
- R2: When `cfg_edge_mode` is 1, only a 0-to-1 transition of `req_in[i]` sets bit i, so a line held high does not set it again after it has been cleared. When `cfg_edge_mode` is 0, every cycle in which the line is high sets the bit, and this setting wins over a same-cycle clear by acknowledge.
- R3: Acknowledge always selects the highest-numbered bit set in `pend_o`, with bit 7 the highest priority and bit 0 the lowest.
- R4: `irq_out` is 1 exactly when `pend_o` is non-zero and no bit of `insvc_o` at or above the position of the highest pending bit is set.
- R5: An acknowledge with auto-EOI off clears the selected bit of `pend_o` and sets the same bit of `insvc_o` on the next clock.
- R6: An acknowledge with `cfg_auto_eoi` at 1 clears the selected pending bit and also clears that line's bit in `insvc_o`, leaving it 0.
- R7: `vec_valid` is 1 for exactly the one cycle after each cycle in which `ack_stb` is 1. In that cycle, for a local vector, `vec_out` holds `cfg_vec_base` with its low 3 bits forced to 0, ORed with the selected line number.
- R8: When `cfg_slave_present` is 1 and the selected line's bit in `cfg_cascade` is 1, `vec_from_slave` is 1 and `vec_out` is 0 in the valid cycle. Otherwise `vec_from_slave` is 0.
- R9: A pulse on `eoi_spec` clears bit `eoi_line` of `insvc_o`. A pulse on `eoi_nonspec` clears the highest set bit of `insvc_o`. After either one, `irq_out` follows R4 using the new in-service state.
- R10: An acknowledge when `pend_o` is 0 returns line 7 ORed into the base, with `vec_from_slave` at 0, and changes neither `pend_o` nor `insvc_o`. A non-specific EOI when `insvc_o` is 0 changes nothing.
- R11: After reset, `pend_o`, `insvc_o`, `irq_out`, `vec_valid` and `vec_from_slave` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 8 | Interrupt request lines |
| cfg_mask | input | 8 | Per-line mask, 1 blocks latching |
| cfg_vec_base | input | 8 | Vector base; low 3 bits ignored |
| cfg_cascade | input | 8 | Lines that have a slave attached |
| cfg_slave_present | input | 1 | A cascaded slave exists |
| cfg_auto_eoi | input | 1 | Retire lines at acknowledge |
| cfg_edge_mode | input | 1 | 1 = rising-edge capture, 0 = level capture |
| eoi_nonspec | input | 1 | Retire the highest in-service line |
| eoi_spec | input | 1 | Retire the line named by eoi_line |
| eoi_line | input | 3 | Line for a specific EOI |
| ack_stb | input | 1 | Acknowledge strobe |
| irq_out | output | 1 | Interrupt output to the processor |
| vec_valid | output | 1 | Vector result valid |
| vec_out | output | 8 | Local vector |
| vec_from_slave | output | 1 | The slave must supply the vector |
| pend_o | output | 8 | Pending-request register |
| insvc_o | output | 8 | In-service register |

## Verification
The bench aims at the places where priority and blocking interact. A lower request waits while a higher line is in service, and a request above that line breaks through; an order reversed by a wrong encoder, or a blocking window of the wrong width, would show up as a wrong vector or a wrong `irq_out`. A line held high across an acknowledge must come back in level mode and stay cleared in edge mode, and a latch that mixed these up would repeat or lose interrupts. The bench also acknowledges with nothing pending, issues an EOI with nothing in service, gives a vector base whose low bits are set, and routes a cascaded line with the slave flag on and off. A design that disturbed state, leaked the base's low bits, or produced a local vector for a slave line fails those cases.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int unsigned DEF_LINES = 8;
   localparam int unsigned DEF_VEC_W = 8;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N_LINES = 8,
   localparam int unsigned LW = $clog2(N_LINES)
) (
   input  logic [N_LINES-1:0] bits_i,
   output logic               any_o,
   output logic [LW-1:0]      top_o
);
   // later (higher) indices overwrite earlier ones: highest set bit wins
   always_comb begin
      top_o = '0;
      for (int i = 0; i < N_LINES; i++) begin
         if (bits_i[i]) top_o = LW'(i);
      end
   end
   assign any_o = |bits_i;

   always_comb begin
      if (any_o) a_top_set_r3 : assert (bits_i[top_o]);
      if (any_o) a_none_above_r3 : assert ((bits_i >> top_o) == 1);
   end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int unsigned N_LINES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] req_in,
   input  logic [N_LINES-1:0] mask_i,
   input  logic               edge_mode_i,
   input  logic [N_LINES-1:0] ack_clr_i,
   output logic [N_LINES-1:0] pend_q
);
   logic [N_LINES-1:0] req_prev_q;
   logic [N_LINES-1:0] hit;

   genvar g;
   generate
      for (g = 0; g < N_LINES; g++) begin : g_line
         assign hit[g] = (edge_mode_i ? (req_in[g] & ~req_prev_q[g]) : req_in[g])
                         & ~mask_i[g];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_prev_q <= '0;
         pend_q     <= '0;
      end else begin
         req_prev_q <= req_in;
         pend_q     <= (pend_q & ~ack_clr_i) | hit;
      end
   end

   p_mask_blocks_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(pend_q) & $past(mask_i)) == '0));

   p_edge_only_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode_i |=> ((pend_q & ~$past(pend_q)
                        & ~($past(req_in) & ~$past(req_prev_q))) == '0));
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
   parameter int unsigned N_LINES = 8,
   localparam int unsigned LW = $clog2(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] ack_set_i,
   input  logic [N_LINES-1:0] auto_clr_i,
   input  logic               eoi_nonspec,
   input  logic               eoi_spec,
   input  logic [LW-1:0]      eoi_line,
   output logic [N_LINES-1:0] insvc_q
);
   logic          isv_any;
   logic [LW-1:0] isv_top;
   logic [N_LINES-1:0] eoi_clr;

   irq_prio_enc #(.N_LINES(N_LINES)) u_isv_enc (
      .bits_i(insvc_q),
      .any_o (isv_any),
      .top_o (isv_top)
   );

   always_comb begin
      eoi_clr = '0;
      if (eoi_spec) eoi_clr[eoi_line] = 1'b1;
      if (eoi_nonspec && isv_any) eoi_clr[isv_top] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) insvc_q <= '0;
      else        insvc_q <= (insvc_q & ~eoi_clr & ~auto_clr_i) | ack_set_i;
   end

   p_ack_onehot_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_set_i));

   p_spec_eoi_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_spec && !ack_set_i[eoi_line]) |=> !insvc_q[$past(eoi_line)]);

   p_empty_eoi_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_nonspec && !eoi_spec && insvc_q == '0 && ack_set_i == '0)
      |=> insvc_q == '0);
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
   import irq_prio_pkg::*;
#(
   parameter int unsigned N_LINES = DEF_LINES,
   parameter int unsigned VEC_W   = DEF_VEC_W,
   localparam int unsigned LW = $clog2(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] req_in,
   input  logic [N_LINES-1:0] cfg_mask,
   input  logic [VEC_W-1:0]   cfg_vec_base,
   input  logic [N_LINES-1:0] cfg_cascade,
   input  logic               cfg_slave_present,
   input  logic               cfg_auto_eoi,
   input  logic               cfg_edge_mode,
   input  logic               eoi_nonspec,
   input  logic               eoi_spec,
   input  logic [LW-1:0]      eoi_line,
   input  logic               ack_stb,
   output logic               irq_out,
   output logic               vec_valid,
   output logic [VEC_W-1:0]   vec_out,
   output logic               vec_from_slave,
   output logic [N_LINES-1:0] pend_o,
   output logic [N_LINES-1:0] insvc_o
);
   generate
      if (!is_pow2(N_LINES)) begin : g_bad_lines
         $error("N_LINES must be a power of two, at least 2");
      end
      if (VEC_W <= LW) begin : g_bad_vec
         $error("VEC_W must exceed the line index width");
      end
   endgenerate

   logic          pend_any;
   logic [LW-1:0] pend_top;
   logic [N_LINES-1:0] ack_clr, ack_set, auto_clr, blk_win;
   logic          ack_take;
   logic [LW-1:0] sel_line;

   irq_req_latch #(.N_LINES(N_LINES)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_in     (req_in),
      .mask_i     (cfg_mask),
      .edge_mode_i(cfg_edge_mode),
      .ack_clr_i  (ack_clr),
      .pend_q     (pend_o)
   );

   irq_prio_enc #(.N_LINES(N_LINES)) u_pend_enc (
      .bits_i(pend_o),
      .any_o (pend_any),
      .top_o (pend_top)
   );

   irq_svc_track #(.N_LINES(N_LINES)) u_svc (
      .clk        (clk),
      .rst_n      (rst_n),
      .ack_set_i  (ack_set),
      .auto_clr_i (auto_clr),
      .eoi_nonspec(eoi_nonspec),
      .eoi_spec   (eoi_spec),
      .eoi_line   (eoi_line),
      .insvc_q    (insvc_o)
   );

   // window of in-service positions that block the top pending line
   genvar g;
   generate
      for (g = 0; g < N_LINES; g++) begin : g_win
         assign blk_win[g] = (LW'(g) >= pend_top);
      end
   endgenerate

   assign irq_out  = pend_any && ((insvc_o & blk_win) == '0);
   assign ack_take = ack_stb && pend_any;
   assign sel_line = pend_any ? pend_top : {LW{1'b1}};

   always_comb begin
      ack_clr = '0;
      if (ack_take) ack_clr[pend_top] = 1'b1;
   end
   assign ack_set  = cfg_auto_eoi ? '0 : ack_clr;
   assign auto_clr = cfg_auto_eoi ? ack_clr : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid      <= 1'b0;
         vec_out        <= '0;
         vec_from_slave <= 1'b0;
      end else begin
         vec_valid      <= ack_stb;
         vec_from_slave <= 1'b0;
         if (ack_stb) begin
            if (ack_take && cfg_slave_present && cfg_cascade[pend_top]) begin
               vec_from_slave <= 1'b1;
               vec_out        <= '0;
            end else begin
               vec_out <= {cfg_vec_base[VEC_W-1:LW], sel_line};
            end
         end
      end
   end

   p_irq_needs_pend_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> pend_any);

   p_vec_latency_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |=> vec_valid);

   p_vec_quiet_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !ack_stb |=> !vec_valid);

   p_slave_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      vec_from_slave |-> (vec_valid && vec_out == '0));

   p_ack_moves_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (ack_take && !cfg_auto_eoi && !eoi_spec && !eoi_nonspec)
      |=> insvc_o[$past(pend_top)]);
endmodule

// File: tb/irq_prio_core_tb.sv
module irq_prio_core_tb_top;
   localparam time TCK = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_in = '0, cfg_mask = '0, cfg_vec_base = 8'h40, cfg_cascade = '0;
   logic       cfg_slave_present = 0, cfg_auto_eoi = 0, cfg_edge_mode = 1;
   logic       eoi_nonspec = 0, eoi_spec = 0, ack_stb = 0;
   logic [2:0] eoi_line = '0;
   logic       irq_out, vec_valid, vec_from_slave;
   logic [7:0] vec_out, pend_o, insvc_o;

   int nchk = 0, nbad = 0;

   always #(TCK/2) clk = ~clk;

   irq_prio_core dut_i (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .cfg_mask(cfg_mask),
      .cfg_vec_base(cfg_vec_base), .cfg_cascade(cfg_cascade),
      .cfg_slave_present(cfg_slave_present), .cfg_auto_eoi(cfg_auto_eoi),
      .cfg_edge_mode(cfg_edge_mode), .eoi_nonspec(eoi_nonspec),
      .eoi_spec(eoi_spec), .eoi_line(eoi_line), .ack_stb(ack_stb),
      .irq_out(irq_out), .vec_valid(vec_valid), .vec_out(vec_out),
      .vec_from_slave(vec_from_slave), .pend_o(pend_o), .insvc_o(insvc_o)
   );

   // ---------------- behavioural reference ----------------
   logic [7:0] m_pend = '0, m_insvc = '0, m_prev = '0, m_vec = '0;
   logic       m_vv = 0, m_slv = 0;

   function automatic int top_of(input logic [7:0] v);
      int r = -1;
      for (int i = 0; i < 8; i++) if (v[i]) r = i;
      return r;
   endfunction

   function automatic logic m_irq();
      int h = top_of(m_pend);
      if (h < 0) return 1'b0;
      return ((m_insvc >> h) == 0);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend = '0; m_insvc = '0; m_prev = '0; m_vec = '0; m_vv = 0; m_slv = 0;
      end else begin
         logic [7:0] setv, aclr, aset, autoc, eclr;
         int h, hi;
         setv = (cfg_edge_mode ? (req_in & ~m_prev) : req_in) & ~cfg_mask;
         aclr = '0; aset = '0; autoc = '0; eclr = '0;
         h = top_of(m_pend);
         m_vv = ack_stb;
         m_slv = 0;
         if (ack_stb) begin
            if (h >= 0) begin
               aclr[h] = 1'b1;
               if (cfg_auto_eoi) autoc[h] = 1'b1; else aset[h] = 1'b1;
               if (cfg_slave_present && cfg_cascade[h]) begin
                  m_slv = 1; m_vec = '0;
               end else m_vec = (cfg_vec_base & 8'hF8) | 8'(h);
            end else m_vec = (cfg_vec_base & 8'hF8) | 8'h07;
         end
         if (eoi_spec) eclr[eoi_line] = 1'b1;
         hi = top_of(m_insvc);
         if (eoi_nonspec && hi >= 0) eclr[hi] = 1'b1;
         m_pend  = (m_pend & ~aclr) | setv;
         m_insvc = (m_insvc & ~eclr & ~autoc) | aset;
         m_prev  = req_in;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      chk("R1 pending register", pend_o, m_pend);
      chk("R5 in-service register", insvc_o, m_insvc);
      chk("R4 interrupt output", irq_out, m_irq());
      chk("R7 vector valid", vec_valid, m_vv);
      if (m_vv && !m_slv) chk("R7 vector value", vec_out, m_vec);
      chk("R8 slave flag", vec_from_slave, m_slv);
   endtask

   task automatic pulse(input logic [7:0] r);
      req_in = r; cyc(); req_in = '0; cyc();
   endtask

   task automatic ack();
      ack_stb = 1; cyc(); ack_stb = 0;
   endtask

   task automatic eoi_n();
      eoi_nonspec = 1; cyc(); eoi_nonspec = 0;
   endtask

   task automatic eoi_s(input logic [2:0] l);
      eoi_spec = 1; eoi_line = l; cyc(); eoi_spec = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      @(negedge clk);
      cyc(); cyc();
      chk("R11 reset pending", pend_o, 0);
      chk("R11 reset in-service", insvc_o, 0);
      chk("R11 reset irq", irq_out, 0);
      chk("R11 reset valid", vec_valid, 0);
      chk("R11 reset slave flag", vec_from_slave, 0);
      rst_n = 1; cyc();

      // R1 masking
      cfg_mask = 8'h20; pulse(8'h20);
      chk("R1 masked line not latched", pend_o, 8'h00);
      cfg_mask = 8'h00; pulse(8'h04);
      chk("R1 unmasked line latched", pend_o, 8'h04);

      // R2 edge mode: held line not relatched
      req_in = 8'h02; cyc();
      ack();
      chk("R3 top line vector", vec_out, 8'h42);
      ack();
      chk("R5 second ack line 1", vec_out, 8'h41);
      cyc(); cyc();
      chk("R2 edge mode no relatch", pend_o, 8'h00);
      req_in = 8'h00; cyc();
      eoi_n();
      chk("R9 nonspecific clears highest", insvc_o, 8'h02);
      eoi_s(3'd1);
      chk("R9 specific clears line", insvc_o, 8'h00);

      // R2 level mode: held line relatches over ack
      cfg_edge_mode = 0; req_in = 8'h02; cyc();
      ack();
      chk("R2 level mode relatch", pend_o, 8'h02);
      req_in = 8'h00; cfg_edge_mode = 1; cyc();
      ack(); cyc();
      eoi_s(3'd1);

      // R3 / R4 priority and blocking
      pulse(8'h26);
      chk("R4 irq raised", irq_out, 1);
      ack();
      chk("R3 highest of 0x26", vec_out, 8'h45);
      chk("R4 lower lines blocked", irq_out, 0);
      pulse(8'h80);
      chk("R4 higher line breaks through", irq_out, 1);
      ack();
      chk("R3 line 7 vector", vec_out, 8'h47);
      eoi_n();
      chk("R9 retire line 7", insvc_o, 8'h20);
      chk("R4 still blocked by line 5", irq_out, 0);
      eoi_n();
      chk("R9 irq rises again", irq_out, 1);

      // R6 auto-EOI
      cfg_auto_eoi = 1;
      ack();
      chk("R6 auto-EOI leaves in-service clear", insvc_o, 8'h00);
      chk("R6 pending cleared", pend_o, 8'h02);
      ack();
      cfg_auto_eoi = 0; cyc();

      // R8 cascade
      cfg_slave_present = 1; cfg_cascade = 8'h08;
      pulse(8'h08); ack();
      chk("R8 slave flag set", vec_from_slave, 1);
      chk("R8 vector zero when deferred", vec_out, 8'h00);
      eoi_s(3'd3);
      cfg_slave_present = 0;
      pulse(8'h08); ack();
      chk("R8 no slave gives local vector", vec_out, 8'h43);
      chk("R8 flag clear without slave", vec_from_slave, 0);
      eoi_s(3'd3);

      // R10 empty acknowledge and empty EOI
      ack();
      chk("R10 empty ack vector", vec_out, 8'h47);
      chk("R10 empty ack pending", pend_o, 8'h00);
      chk("R10 empty ack in-service", insvc_o, 8'h00);
      eoi_n();
      chk("R10 empty EOI no change", insvc_o, 8'h00);

      // R7 base low bits forced to zero, valid one cycle only
      cfg_vec_base = 8'h9D;
      pulse(8'h10); ack();
      chk("R7 base low bits dropped", vec_out, 8'h9C);
      chk("R7 valid asserted", vec_valid, 1);
      cyc();
      chk("R7 valid single cycle", vec_valid, 0);
      eoi_n(); cyc();

      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule